// File: doc/BRIEF.md
# ZQ Calibration Command Scheduler

This block sits on the controller side of a DDR3 channel and decides when each rank gets a long or a short impedance calibration command. It keeps one pending long request and one pending short request per rank. A request is served only when that rank's banks are all closed, the precharge recovery time has run out, and no self-refresh exit recovery is still counting. Once the main command arbiter grants the request, the scheduler keeps the channel quiet for a window whose length depends on the command type and, for long commands, on whether this is the rank's first long calibration since reset.

Every rank gets a long calibration automatically during power-up, once the init sequencer reports that the device is ready for it. The channel stays blocked until every rank has finished that first window. After that, an optional programmable interval timer queues short calibrations for all ranks. Each self-refresh exit queues a short calibration for the rank that woke, and the controller can ask for a long calibration at any time. All ranks share one calibration resistor, so only one window is ever open at a time. When several ranks are ready, the lowest rank index goes first.

Top module: `zq_cal_sched`

## Requirements
- R1: After reset, `zq_req_o` is 0, `chan_block_o` is 1 and `odt_off_o` is 0. No request is raised while `pwrup_ready_i` is 0.
- R2: The first long command of each rank after reset is sent with `zq_a10_o`=1 and opens a window of `cfg_tzqinit_i` cycles. `chan_block_o` stays 1 until the first windows of all ranks have ended, and drops in the first cycle after that.
- R3: Every later long command (`zq_a10_o`=1) opens a window of `cfg_tzqoper_i` cycles.
- R4: A short command is sent with `zq_a10_o`=0 and opens a window of `cfg_tzqcs_i` cycles.
- R5: A window starts in the cycle after the grant. Throughout the window, `zq_req_o` is 0 and both `chan_block_o` and `odt_off_o` are 1. While a request is raised, `chan_block_o` and `odt_off_o` are also 1.
- R6: A raised request stays raised, with `zq_a10_o` and `zq_rank_o` unchanged, until `grant_i` is seen high.
- R7: A rank is not requested while its `banks_idle_i` bit is 0. After a `prech_i` pulse, the rank's request appears no sooner than `cfg_trp_i`+1 cycles later.
- R8: A `srx_i` pulse queues a short command for that rank. The request appears `cfg_txs_i`+1 cycles after the pulse, and no earlier.
- R9: At most one window is open at a time. When several ranks are ready, the lowest index is served first. The next request comes only after the previous window has ended.
- R10: If a long and a short request are both pending for one rank, a single long command is sent and the short request is discarded.
- R11: Once the initial calibration is complete, a non-zero `cfg_interval_i` queues a short command for every rank once every `cfg_interval_i` cycles. A value of 0 stops the periodic requests.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pwrup_ready_i | input | 1 | Init sequencer has reached the calibration step |
| banks_idle_i | input | NUM_RANKS | Per rank: all banks precharged |
| prech_i | input | NUM_RANKS | Per rank: precharge issued this cycle |
| srx_i | input | NUM_RANKS | Per rank: self-refresh exit this cycle |
| long_req_i | input | NUM_RANKS | Per rank: request a long calibration |
| grant_i | input | 1 | Arbiter accepts the raised request |
| cfg_tzqinit_i | input | TW | First long window length, cycles |
| cfg_tzqoper_i | input | TW | Later long window length, cycles |
| cfg_tzqcs_i | input | TW | Short window length, cycles |
| cfg_trp_i | input | TW | Precharge recovery, cycles |
| cfg_txs_i | input | TW | Self-refresh exit recovery, cycles |
| cfg_interval_i | input | IW | Periodic short interval, 0 = off |
| zq_req_o | output | 1 | Calibration command request |
| zq_a10_o | output | 1 | A10 level: 1 long, 0 short |
| zq_rank_o | output | RW | Target rank of the request |
| chan_block_o | output | 1 | Block all other channel commands |
| odt_off_o | output | 1 | Force ODT disabled |

## Verification
The key corner case is window length. A design that never tracks the first long command per rank would use the wrong long length after power-up. A design that tracks it for the whole channel instead of per rank would give rank 1 the short operating length during init. The bench counts recovery cycles exactly after precharge and after self-refresh exit, so a counter that is off by one, or that ignores the exit, makes the request appear at the wrong cycle. It also sends a long and a short request to one rank at the same time to catch a duplicate short command. Finally, it raises two ranks together to catch windows that overlap or run in the wrong order.

// File: rtl/zq_sched_pkg.sv
package zq_sched_pkg;
  typedef enum logic [1:0] {
    ZQ_IDLE = 2'd0,
    ZQ_REQ  = 2'd1,
    ZQ_WIN  = 2'd2
  } zq_state_e;
endpackage

// File: rtl/zq_rank_track.sv
// Per-rank pending requests and recovery counters.
module zq_rank_track #(
  parameter int TW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          prech_i,
  input  logic          banks_idle_i,
  input  logic          srx_i,
  input  logic          long_req_i,
  input  logic          short_tick_i,
  input  logic          issue_i,
  input  logic          issue_long_i,
  input  logic [TW-1:0] cfg_trp_i,
  input  logic [TW-1:0] cfg_txs_i,
  output logic          ready_o,
  output logic          long_pend_o,
  output logic          first_done_o
);
  logic          pend_long_q, pend_short_q, first_q;
  logic [TW-1:0] trp_cnt_q, txs_cnt_q;
  logic          clr_long, clr_short;

  assign clr_long  = issue_i & issue_long_i;
  assign clr_short = issue_i;  // a long command also covers the short one

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_long_q  <= 1'b1;  // power-up long calibration
      pend_short_q <= 1'b0;
      first_q      <= 1'b0;
    end else begin
      pend_long_q  <= (pend_long_q & ~clr_long) | long_req_i;
      pend_short_q <= (pend_short_q & ~clr_short) | srx_i | short_tick_i;
      if (clr_long) first_q <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      trp_cnt_q <= '0;
      txs_cnt_q <= '0;
    end else begin
      if (prech_i)                trp_cnt_q <= cfg_trp_i;
      else if (trp_cnt_q != '0)   trp_cnt_q <= trp_cnt_q - 1'b1;
      if (srx_i)                  txs_cnt_q <= cfg_txs_i;
      else if (txs_cnt_q != '0)   txs_cnt_q <= txs_cnt_q - 1'b1;
    end
  end

  assign ready_o      = (pend_long_q | pend_short_q) & banks_idle_i &
                        (trp_cnt_q == '0) & (txs_cnt_q == '0);
  assign long_pend_o  = pend_long_q;
  assign first_done_o = first_q;
endmodule

// File: rtl/zq_interval_timer.sv
// Periodic short-calibration tick generator.
module zq_interval_timer #(
  parameter int IW = 20
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          run_i,
  input  logic [IW-1:0] cfg_interval_i,
  output logic          tick_o
);
  logic [IW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || !run_i || cfg_interval_i == '0) begin
      cnt_q  <= '0;
      tick_o <= 1'b0;
    end else if (cnt_q >= cfg_interval_i - 1'b1) begin
      cnt_q  <= '0;
      tick_o <= 1'b1;
    end else begin
      cnt_q  <= cnt_q + 1'b1;
      tick_o <= 1'b0;
    end
  end
endmodule

// File: rtl/zq_seq_fsm.sv
// Picks a ready rank, handshakes with the arbiter, times the quiet window.
module zq_seq_fsm
  import zq_sched_pkg::*;
#(
  parameter int NR = 2,
  parameter int TW = 16,
  parameter int RW = 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          pwrup_ready_i,
  input  logic [NR-1:0] ready_i,
  input  logic [NR-1:0] long_pend_i,
  input  logic [NR-1:0] first_done_i,
  input  logic          grant_i,
  input  logic [TW-1:0] cfg_tzqinit_i,
  input  logic [TW-1:0] cfg_tzqoper_i,
  input  logic [TW-1:0] cfg_tzqcs_i,
  output logic [NR-1:0] issue_o,
  output logic          issue_long_o,
  output logic          init_done_o,
  output logic          zq_req_o,
  output logic          zq_a10_o,
  output logic [RW-1:0] zq_rank_o,
  output logic          chan_block_o,
  output logic          odt_off_o
);
  zq_state_e     state_q, state_n;
  logic [RW-1:0] rank_q, rank_n, pick_idx;
  logic          long_q, long_n, pick_found;
  logic [TW-1:0] cnt_q, cnt_n, len_sel;
  logic          init_q, init_n;

  always_comb begin
    pick_found = 1'b0;
    pick_idx   = '0;
    for (int i = NR - 1; i >= 0; i--) begin
      if (ready_i[i]) begin
        pick_found = 1'b1;
        pick_idx   = RW'(i);
      end
    end
  end

  always_comb begin
    if (long_q) len_sel = first_done_i[rank_q] ? cfg_tzqoper_i : cfg_tzqinit_i;
    else        len_sel = cfg_tzqcs_i;
  end

  always_comb begin
    state_n = state_q;
    rank_n  = rank_q;
    long_n  = long_q;
    cnt_n   = cnt_q;
    unique case (state_q)
      ZQ_IDLE: if (pwrup_ready_i && pick_found) begin
        state_n = ZQ_REQ;
        rank_n  = pick_idx;
        long_n  = long_pend_i[pick_idx];
      end
      ZQ_REQ: if (grant_i) begin
        state_n = ZQ_WIN;
        cnt_n   = (len_sel == '0) ? '0 : len_sel - 1'b1;
      end
      ZQ_WIN: begin
        if (cnt_q == '0) state_n = ZQ_IDLE;
        else             cnt_n   = cnt_q - 1'b1;
      end
      default: state_n = ZQ_IDLE;
    endcase
  end

  always_comb begin
    issue_o = '0;
    if (state_q == ZQ_REQ && grant_i) issue_o[rank_q] = 1'b1;
  end
  assign issue_long_o = long_q;

  assign init_n = init_q |
                  (state_q == ZQ_WIN && cnt_q == '0 && (&first_done_i));

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q      <= ZQ_IDLE;
      rank_q       <= '0;
      long_q       <= 1'b0;
      cnt_q        <= '0;
      init_q       <= 1'b0;
      zq_req_o     <= 1'b0;
      zq_a10_o     <= 1'b0;
      zq_rank_o    <= '0;
      chan_block_o <= 1'b1;
      odt_off_o    <= 1'b0;
    end else begin
      state_q      <= state_n;
      rank_q       <= rank_n;
      long_q       <= long_n;
      cnt_q        <= cnt_n;
      init_q       <= init_n;
      zq_req_o     <= (state_n == ZQ_REQ);
      zq_a10_o     <= long_n;
      zq_rank_o    <= rank_n;
      chan_block_o <= (state_n != ZQ_IDLE) | ~init_n;
      odt_off_o    <= (state_n != ZQ_IDLE);
    end
  end

  assign init_done_o = init_q;
endmodule

// File: rtl/zq_cal_sched.sv
module zq_cal_sched #(
  parameter int NUM_RANKS = 2,
  parameter int TW        = 16,
  parameter int IW        = 20,
  localparam int RW       = (NUM_RANKS > 1) ? $clog2(NUM_RANKS) : 1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 pwrup_ready_i,
  input  logic [NUM_RANKS-1:0] banks_idle_i,
  input  logic [NUM_RANKS-1:0] prech_i,
  input  logic [NUM_RANKS-1:0] srx_i,
  input  logic [NUM_RANKS-1:0] long_req_i,
  input  logic                 grant_i,
  input  logic [TW-1:0]        cfg_tzqinit_i,
  input  logic [TW-1:0]        cfg_tzqoper_i,
  input  logic [TW-1:0]        cfg_tzqcs_i,
  input  logic [TW-1:0]        cfg_trp_i,
  input  logic [TW-1:0]        cfg_txs_i,
  input  logic [IW-1:0]        cfg_interval_i,
  output logic                 zq_req_o,
  output logic                 zq_a10_o,
  output logic [RW-1:0]        zq_rank_o,
  output logic                 chan_block_o,
  output logic                 odt_off_o
);
  logic [NUM_RANKS-1:0] ready, long_pend, first_done, issue;
  logic                 issue_long, init_done, short_tick;

  zq_interval_timer #(.IW(IW)) u_timer (
    .clk(clk), .rst(rst), .run_i(init_done),
    .cfg_interval_i(cfg_interval_i), .tick_o(short_tick)
  );

  for (genvar r = 0; r < NUM_RANKS; r++) begin : g_rank
    zq_rank_track #(.TW(TW)) u_trk (
      .clk(clk), .rst(rst),
      .prech_i(prech_i[r]), .banks_idle_i(banks_idle_i[r]),
      .srx_i(srx_i[r]), .long_req_i(long_req_i[r]),
      .short_tick_i(short_tick),
      .issue_i(issue[r]), .issue_long_i(issue_long),
      .cfg_trp_i(cfg_trp_i), .cfg_txs_i(cfg_txs_i),
      .ready_o(ready[r]), .long_pend_o(long_pend[r]),
      .first_done_o(first_done[r])
    );
  end

  zq_seq_fsm #(.NR(NUM_RANKS), .TW(TW), .RW(RW)) u_fsm (
    .clk(clk), .rst(rst), .pwrup_ready_i(pwrup_ready_i),
    .ready_i(ready), .long_pend_i(long_pend), .first_done_i(first_done),
    .grant_i(grant_i),
    .cfg_tzqinit_i(cfg_tzqinit_i), .cfg_tzqoper_i(cfg_tzqoper_i),
    .cfg_tzqcs_i(cfg_tzqcs_i),
    .issue_o(issue), .issue_long_o(issue_long), .init_done_o(init_done),
    .zq_req_o(zq_req_o), .zq_a10_o(zq_a10_o), .zq_rank_o(zq_rank_o),
    .chan_block_o(chan_block_o), .odt_off_o(odt_off_o)
  );
endmodule

// File: rtl/zq_cal_sched_chk.sv
module zq_cal_sched_chk #(
  parameter int NUM_RANKS = 2,
  parameter int TW        = 16,
  parameter int RW        = 1
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 pwrup_ready_i,
  input logic [NUM_RANKS-1:0] banks_idle_i,
  input logic                 grant_i,
  input logic [TW-1:0]        cfg_tzqinit_i,
  input logic [TW-1:0]        cfg_tzqoper_i,
  input logic [TW-1:0]        cfg_tzqcs_i,
  input logic                 zq_req_o,
  input logic                 zq_a10_o,
  input logic [RW-1:0]        zq_rank_o,
  input logic                 chan_block_o,
  input logic                 odt_off_o
);
  logic [NUM_RANKS-1:0] seen_long_q;
  logic [TW-1:0]        win_len_q, exp_len_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      seen_long_q <= '0;
      win_len_q   <= '0;
      exp_len_q   <= '0;
    end else if (zq_req_o && grant_i) begin
      win_len_q <= '0;
      if (zq_a10_o) begin
        exp_len_q <= seen_long_q[zq_rank_o] ? cfg_tzqoper_i : cfg_tzqinit_i;
        seen_long_q[zq_rank_o] <= 1'b1;
      end else begin
        exp_len_q <= cfg_tzqcs_i;
      end
    end else if (odt_off_o && !zq_req_o) begin
      win_len_q <= win_len_q + 1'b1;
    end
  end

  // R5: quiet window follows the grant
  a_r5_quiet_after_grant: assert property (@(posedge clk) disable iff (rst)
    (zq_req_o && grant_i) |=> (!zq_req_o && odt_off_o && chan_block_o));

  // R5: request implies blocking and ODT off
  a_r5_req_blocks: assert property (@(posedge clk) disable iff (rst)
    zq_req_o |-> (odt_off_o && chan_block_o));

  // R6: request held stable until granted
  a_r6_hold_until_grant: assert property (@(posedge clk) disable iff (rst)
    (zq_req_o && !grant_i) |=> (zq_req_o && $stable(zq_a10_o) && $stable(zq_rank_o)));

  // R7: never request a rank with open banks
  a_r7_banks_idle: assert property (@(posedge clk) disable iff (rst)
    (zq_req_o && $rose(zq_req_o)) |-> banks_idle_i[zq_rank_o]);

  // R1: no new request while power-up is not ready
  a_r1_pwrup_gate: assert property (@(posedge clk) disable iff (rst)
    (!pwrup_ready_i && !zq_req_o) |=> !zq_req_o);

  // R2 R3 R4: window length matches command kind and history
  a_r4_window_len: assert property (@(posedge clk) disable iff (rst)
    $fell(odt_off_o) |-> (win_len_q == exp_len_q));
endmodule

bind zq_cal_sched zq_cal_sched_chk #(.NUM_RANKS(NUM_RANKS), .TW(TW), .RW(RW)) u_chk (.*);

// File: tb/test_zq_cal_sched.sv
`timescale 1ns/1ps
module test_zq_cal_sched;
  localparam int NR = 2, TW = 16, IW = 20;
  localparam int T_INIT = 40, T_OPER = 20, T_CS = 6, T_RP = 4, T_XS = 5;
  // vector: [9] rank, [8] long, [7:0] expected window
  localparam logic [9:0] VEC [4] = '{
    {1'b0, 1'b1, 8'(T_OPER)},
    {1'b1, 1'b0, 8'(T_CS)},
    {1'b1, 1'b1, 8'(T_OPER)},
    {1'b0, 1'b0, 8'(T_CS)}
  };

  logic clk = 1'b0, rst = 1'b1, pwrup = 1'b0, grant = 1'b0;
  logic [NR-1:0] banks_idle = '1, prech = '0, srx = '0, long_req = '0;
  logic [IW-1:0] interval = '0;
  logic zq_req, zq_a10, zq_rank, block, odt_off;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;  // 250 MHz

  zq_cal_sched #(.NUM_RANKS(NR), .TW(TW), .IW(IW)) i_zq_cal_sched (
    .clk(clk), .rst(rst), .pwrup_ready_i(pwrup), .banks_idle_i(banks_idle),
    .prech_i(prech), .srx_i(srx), .long_req_i(long_req), .grant_i(grant),
    .cfg_tzqinit_i(TW'(T_INIT)), .cfg_tzqoper_i(TW'(T_OPER)),
    .cfg_tzqcs_i(TW'(T_CS)), .cfg_trp_i(TW'(T_RP)), .cfg_txs_i(TW'(T_XS)),
    .cfg_interval_i(interval),
    .zq_req_o(zq_req), .zq_a10_o(zq_a10), .zq_rank_o(zq_rank),
    .chan_block_o(block), .odt_off_o(odt_off)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic serve(input int rank, input int lng, input int win, input string req);
    int n = 0;
    while (!zq_req && n < 300) begin @(negedge clk); n++; end
    chk(zq_req == 1'b1, {req, " request raised"}, int'(zq_req), 1);
    chk(int'(zq_rank) == rank, {req, " rank"}, int'(zq_rank), rank);
    chk(int'(zq_a10) == lng, {req, " A10"}, int'(zq_a10), lng);
    chk(block && odt_off, "R5 block/odt during request", int'({block, odt_off}), 3);
    grant = 1'b1;
    @(negedge clk);
    grant = 1'b0;
    n = 0;
    while (odt_off && n < 1000) begin
      if (zq_req || !block) begin
        chk(1'b0, "R5 quiet window", int'({zq_req, block}), 1);
      end
      n++;
      @(negedge clk);
    end
    chk(n == win, {req, " window length"}, n, win);
  endtask

  task automatic pulse(input int which, input int rank);
    @(negedge clk);
    case (which)
      0: long_req[rank] = 1'b1;
      1: srx[rank] = 1'b1;
      default: prech[rank] = 1'b1;
    endcase
    @(negedge clk);
    long_req = '0; srx = '0; prech = '0;
  endtask

  task automatic quiet(input int cycles, input string req);
    int seen = 0;
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      if (zq_req) seen++;
    end
    chk(seen == 0, req, seen, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk(!zq_req, "R1 req after reset", int'(zq_req), 0);
    chk(block, "R1 block after reset", int'(block), 1);
    chk(!odt_off, "R1 odt after reset", int'(odt_off), 0);
    quiet(10, "R1 no request before power-up ready");
    pwrup = 1'b1;
    // R2 first long per rank, init length, R9 order
    serve(0, 1, T_INIT, "R2 init rank0");
    chk(block, "R2 block held between init windows", int'(block), 1);
    serve(1, 1, T_INIT, "R2 init rank1");
    chk(!block, "R2 block released after init", int'(block), 0);

    // table walk: R3 and R4
    foreach (VEC[k]) begin
      pulse(VEC[k][8] ? 0 : 1, int'(VEC[k][9]));
      serve(int'(VEC[k][9]), int'(VEC[k][8]), int'(VEC[k][7:0]),
            VEC[k][8] ? "R3 table long" : "R4 table short");
    end

    // R7 precharge recovery
    begin
      int n = 0;
      @(negedge clk);
      prech[0] = 1'b1; long_req[0] = 1'b1;
      @(negedge clk);
      prech = '0; long_req = '0;
      while (!zq_req && n < 100) begin n++; @(negedge clk); end
      chk(n == T_RP + 1, "R7 precharge recovery delay", n, T_RP + 1);
      serve(0, 1, T_OPER, "R7 after recovery");
    end

    // R8 self-refresh exit recovery
    begin
      int n = 0;
      @(negedge clk);
      srx[1] = 1'b1;
      @(negedge clk);
      srx = '0;
      while (!zq_req && n < 100) begin n++; @(negedge clk); end
      chk(n == T_XS + 1, "R8 exit recovery delay", n, T_XS + 1);
      serve(1, 0, T_CS, "R8 short after exit");
    end

    // R7 open banks hold off
    banks_idle[0] = 1'b0;
    pulse(0, 0);
    quiet(20, "R7 no request with open banks");
    banks_idle[0] = 1'b1;
    serve(0, 1, T_OPER, "R7 after banks close");

    // R10 long and short together
    @(negedge clk);
    srx[0] = 1'b1; long_req[0] = 1'b1;
    @(negedge clk);
    srx = '0; long_req = '0;
    serve(0, 1, T_OPER, "R10 long wins");
    quiet(30, "R10 short dropped");

    // R9 two ranks at once
    @(negedge clk);
    long_req = '1;
    @(negedge clk);
    long_req = '0;
    serve(0, 1, T_OPER, "R9 rank0 first");
    chk(!zq_req, "R9 no request right at window end", int'(zq_req), 0);
    serve(1, 1, T_OPER, "R9 rank1 second");

    // R6 hold until grant
    pulse(0, 1);
    while (!zq_req) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      if (!(zq_req && zq_rank == 1'b1 && zq_a10 && block)) begin
        chk(1'b0, "R6 request held", int'({zq_req, zq_rank, zq_a10}), 7);
      end
    end
    chk(zq_req, "R6 still raised after wait", int'(zq_req), 1);
    serve(1, 1, T_OPER, "R6 granted late");

    // R11 periodic requests
    quiet(60, "R11 interval zero disables");
    interval = IW'(30);
    serve(0, 0, T_CS, "R11 periodic rank0");
    serve(1, 0, T_CS, "R11 periodic rank1");
    interval = '0;
    quiet(80, "R11 stopped after zero");

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule